// File: doc/BRIEF.md
# Bus-Master DMA Register Window

This block is the byte-wide control window that a host uses to steer the bus-master DMA engines of a two-channel disk controller. A 16-byte I/O region holds one 8-byte slot per channel; the low four bytes of each slot are this window, and the upper four bytes belong to the descriptor-table address port, which lives elsewhere. Inside the window, a two-bit offset selects a command byte, a view of the mode and interrupt byte that both channels share, a status byte, and a per-channel drive timing byte.

The window honours single-byte accesses only. A command write is passed to the DMA engine as a one-cycle strobe and is also kept for read-back. The shared mode byte is owned by the interrupt logic beside this block. This block reads that byte in full and sends out a write request that carries only the two interrupt-block bits. Status mixes three kinds of bit: a live engine-active bit, two sticky event flags that software clears by writing one, and two plain read/write bits.

Reads are combinational from the address and size inputs. Writes take effect at the clock edge where `io_wr` is high.

Top module: `bmdma_regwin`

## Requirements
- R1: The size code `io_size` selects the access width: 0 is 1 byte, 1 is 2 bytes, and 2 or 3 is 4 bytes. Inside the window, any wider read returns all ones of its width: 0x0000FFFF for 2 bytes and 0xFFFFFFFF for 4 bytes. A wider write changes no register and raises no strobe.
- R2: Address bit 3 selects the channel, address bit 2 set marks the address port, and bits 1:0 give the offset. An access with bit 2 set reads 0 and a write to it has no effect.
- R3: A byte write to offset 0 raises `cmd_stb` for that channel, and only that channel, for exactly one cycle after the write edge. At the same time `cmd_byte` shows the written byte. Offset 0 reads back the last command byte written to that channel.
- R4: A byte read at offset 1 returns `mode_in` on bits 7:0 from either channel.
- R5: A byte write to offset 1 pulses `mode_wr` for one cycle after the edge, with `mode_wr_mask` set to data bits 5:4. It stores nothing in this block.
- R6: Status bit 0 equals that channel's `eng_busy` input at all times and ignores writes.
- R7: Status bit 1 (error) and bit 2 (interrupt) are set by the `eng_err_evt` and `eng_irq_evt` inputs and stay set. A status write clears each of these bits where the written data has a 1. An event in the same cycle as a clear wins.
- R8: Status bits 6:5 hold the last written data bits 6:5. Status bits 7, 4 and 3 read as 0.
- R9: A byte write to offset 3 stores the whole byte as that channel's timing byte. The byte reads back at offset 3 and drives `tim_bytes` (channel c on bits 8c+7:8c). No other access changes it.
- R10: After reset, the command, timing and status storage are zero, and no strobe is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_wr | input | 1 | Write enable for the current access |
| io_addr | input | 4 | Byte address within the 16-byte region |
| io_size | input | 2 | Access width code |
| io_wdata | input | 32 | Write data (byte in bits 7:0) |
| io_rdata | output | 32 | Read data for the current address and size |
| mode_in | input | 8 | Current value of the shared mode byte |
| mode_wr | output | 1 | One-cycle request to update the mode byte's block bits |
| mode_wr_mask | output | 2 | New values for mode bits 5:4 |
| eng_busy | input | 2 | Per-channel engine-active level |
| eng_err_evt | input | 2 | Per-channel error event pulse |
| eng_irq_evt | input | 2 | Per-channel interrupt event pulse |
| cmd_stb | output | 2 | Per-channel command strobe |
| cmd_byte | output | 8 | Command byte that goes with `cmd_stb` |
| tim_bytes | output | 16 | Per-channel timing bytes |

## Verification
The assertions assume that the host keeps `io_wr` low during reset. They also assume that `eng_err_evt` and `eng_irq_evt` are clean single-cycle levels sampled at the clock, and that `io_size` is always one of the four codes. The stimulus meets these assumptions by driving every input on the falling edge and holding writes and events at zero while reset is active. It then clears the write and event inputs after each step. Events and status clears are drawn at random so that they sometimes land in the same cycle. Directed steps force that collision and also cover wide accesses.

// File: rtl/bmw_pkg.sv
package bmw_pkg;

  localparam int ACC_W  = 32;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    OFS_CMD  = 2'd0,
    OFS_MODE = 2'd1,
    OFS_STAT = 2'd2,
    OFS_TIME = 2'd3
  } win_ofs_e;

  typedef enum logic [1:0] {
    SZ_B1  = 2'd0,
    SZ_B2  = 2'd1,
    SZ_B4  = 2'd2,
    SZ_B4X = 2'd3
  } acc_size_e;

  // All-ones pattern for an access of the given width
  function automatic logic [ACC_W-1:0] wide_fill(input logic [1:0] sz);
    case (sz)
      SZ_B1:   wide_fill = {{(ACC_W-8){1'b0}}, 8'hFF};
      SZ_B2:   wide_fill = {{(ACC_W-16){1'b0}}, 16'hFFFF};
      default: wide_fill = {ACC_W{1'b1}};
    endcase
  endfunction

  // Status byte layout: [6:5] plain r/w, [2] irq flag, [1] error flag, [0] active
  function automatic logic [BYTE_W-1:0] status_view(input logic       busy,
                                                    input logic [1:0] flags,
                                                    input logic [1:0] rw);
    status_view = {1'b0, rw, 2'b00, flags, busy};
  endfunction

  // Sticky flags: clear-by-one, then set by events (set wins)
  function automatic logic [1:0] flags_next(input logic [1:0] cur,
                                            input logic [1:0] clr,
                                            input logic [1:0] set);
    flags_next = (cur & ~clr) | set;
  endfunction

endpackage

// File: rtl/bmw_decode.sv
module bmw_decode
  import bmw_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int CH_W   = 1,
  parameter int AW     = 4
) (
  input  logic              io_wr,
  input  logic [AW-1:0]     io_addr,
  input  logic [1:0]        io_size,
  output logic              win_hit,
  output logic              byte_acc,
  output logic [CH_W-1:0]   ch_sel,
  output win_ofs_e          ofs,
  output logic [NUM_CH-1:0] wr_cmd,
  output logic [NUM_CH-1:0] wr_stat,
  output logic [NUM_CH-1:0] wr_tim,
  output logic              wr_mode
);

  logic wr_ok;

  assign win_hit  = ~io_addr[2];
  assign byte_acc = (io_size == SZ_B1);
  assign ch_sel   = io_addr[AW-1:3];
  assign ofs      = win_ofs_e'(io_addr[1:0]);
  assign wr_ok    = io_wr & win_hit & byte_acc;
  assign wr_mode  = wr_ok && (ofs == OFS_MODE);

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch_dec
    logic ch_hit;
    assign ch_hit     = wr_ok && (ch_sel == CH_W'(g));
    assign wr_cmd[g]  = ch_hit && (ofs == OFS_CMD);
    assign wr_stat[g] = ch_hit && (ofs == OFS_STAT);
    assign wr_tim[g]  = ch_hit && (ofs == OFS_TIME);
  end

endmodule

// File: rtl/bmw_chan_regs.sv
module bmw_chan_regs
  import bmw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_cmd,
  input  logic              wr_stat,
  input  logic              wr_tim,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              busy,
  input  logic              err_evt,
  input  logic              irq_evt,
  output logic [BYTE_W-1:0] cmd_q,
  output logic [BYTE_W-1:0] stat_rd,
  output logic [BYTE_W-1:0] tim_q,
  output logic              cmd_stb_q
);

  logic [1:0] flags_q;
  logic [1:0] rw_q;
  logic [1:0] clr_req;
  logic [1:0] set_req;

  assign clr_req = wr_stat ? wdata[2:1] : 2'b00;
  assign set_req = {irq_evt, err_evt};
  assign stat_rd = status_view(busy, flags_q, rw_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q     <= '0;
      tim_q     <= '0;
      flags_q   <= '0;
      rw_q      <= '0;
      cmd_stb_q <= 1'b0;
    end else begin
      cmd_stb_q <= wr_cmd;
      if (wr_cmd)  cmd_q <= wdata;
      if (wr_tim)  tim_q <= wdata;
      if (wr_stat) rw_q  <= wdata[6:5];
      flags_q <= flags_next(flags_q, clr_req, set_req);
    end
  end

  AST_ERR_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    err_evt |=> stat_rd[1]); // R7
  AST_IRQ_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    irq_evt |=> stat_rd[2]); // R7
  AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_stat && !err_evt && !irq_evt) |=> $stable(flags_q)); // R7
  AST_RW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stat |=> $stable(rw_q)); // R8
  AST_TIM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_tim |=> $stable(tim_q)); // R9
  AST_ZERO_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd[7] == 1'b0) && (stat_rd[4:3] == 2'b00)); // R8

endmodule

// File: rtl/bmw_rdmux.sv
module bmw_rdmux
  import bmw_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int CH_W   = 1
) (
  input  logic                          win_hit,
  input  logic                          byte_acc,
  input  logic [1:0]                    io_size,
  input  logic [CH_W-1:0]               ch_sel,
  input  win_ofs_e                      ofs,
  input  logic [NUM_CH-1:0][BYTE_W-1:0] cmd_arr,
  input  logic [NUM_CH-1:0][BYTE_W-1:0] stat_arr,
  input  logic [NUM_CH-1:0][BYTE_W-1:0] tim_arr,
  input  logic [BYTE_W-1:0]             mode_in,
  output logic [ACC_W-1:0]              rdata
);

  logic [BYTE_W-1:0] sel_cmd, sel_stat, sel_tim, sel_byte;

  always_comb begin
    sel_cmd  = '0;
    sel_stat = '0;
    sel_tim  = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (ch_sel == CH_W'(c)) begin
        sel_cmd  = cmd_arr[c];
        sel_stat = stat_arr[c];
        sel_tim  = tim_arr[c];
      end
    end
  end

  always_comb begin
    case (ofs)
      OFS_CMD:  sel_byte = sel_cmd;
      OFS_MODE: sel_byte = mode_in;
      OFS_STAT: sel_byte = sel_stat;
      default:  sel_byte = sel_tim;
    endcase
  end

  always_comb begin
    if (!win_hit)       rdata = '0;
    else if (!byte_acc) rdata = wide_fill(io_size);
    else                rdata = {{(ACC_W-BYTE_W){1'b0}}, sel_byte};
  end

endmodule

// File: rtl/bmdma_regwin.sv
module bmdma_regwin
  import bmw_pkg::*;
#(
  parameter int NUM_CH = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 io_wr,
  input  logic [3:0]           io_addr,
  input  logic [1:0]           io_size,
  input  logic [31:0]          io_wdata,
  output logic [31:0]          io_rdata,
  input  logic [7:0]           mode_in,
  output logic                 mode_wr,
  output logic [1:0]           mode_wr_mask,
  input  logic [NUM_CH-1:0]    eng_busy,
  input  logic [NUM_CH-1:0]    eng_err_evt,
  input  logic [NUM_CH-1:0]    eng_irq_evt,
  output logic [NUM_CH-1:0]    cmd_stb,
  output logic [7:0]           cmd_byte,
  output logic [NUM_CH*8-1:0]  tim_bytes
);

  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam int AW   = CH_W + 3;

  logic                          win_hit, byte_acc, wr_mode;
  logic [CH_W-1:0]               ch_sel;
  win_ofs_e                      ofs;
  logic [NUM_CH-1:0]             wr_cmd, wr_stat, wr_tim;
  logic [NUM_CH-1:0][BYTE_W-1:0] cmd_arr, stat_arr, tim_arr;
  logic                          unused_wdata_hi;

  assign unused_wdata_hi = ^io_wdata[31:8];

  bmw_decode #(.NUM_CH(NUM_CH), .CH_W(CH_W), .AW(AW)) u_dec (
    .io_wr    (io_wr),
    .io_addr  (io_addr[AW-1:0]),
    .io_size  (io_size),
    .win_hit  (win_hit),
    .byte_acc (byte_acc),
    .ch_sel   (ch_sel),
    .ofs      (ofs),
    .wr_cmd   (wr_cmd),
    .wr_stat  (wr_stat),
    .wr_tim   (wr_tim),
    .wr_mode  (wr_mode)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
    bmw_chan_regs u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_cmd    (wr_cmd[g]),
      .wr_stat   (wr_stat[g]),
      .wr_tim    (wr_tim[g]),
      .wdata     (io_wdata[7:0]),
      .busy      (eng_busy[g]),
      .err_evt   (eng_err_evt[g]),
      .irq_evt   (eng_irq_evt[g]),
      .cmd_q     (cmd_arr[g]),
      .stat_rd   (stat_arr[g]),
      .tim_q     (tim_arr[g]),
      .cmd_stb_q (cmd_stb[g])
    );
  end

  bmw_rdmux #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_rd (
    .win_hit  (win_hit),
    .byte_acc (byte_acc),
    .io_size  (io_size),
    .ch_sel   (ch_sel),
    .ofs      (ofs),
    .cmd_arr  (cmd_arr),
    .stat_arr (stat_arr),
    .tim_arr  (tim_arr),
    .mode_in  (mode_in),
    .rdata    (io_rdata)
  );

  assign tim_bytes = tim_arr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_wr      <= 1'b0;
      mode_wr_mask <= '0;
      cmd_byte     <= '0;
    end else begin
      mode_wr <= wr_mode;
      if (wr_mode)  mode_wr_mask <= io_wdata[5:4];
      if (|wr_cmd)  cmd_byte     <= io_wdata[7:0];
    end
  end

  AST_WIDE_WRITE_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_size != SZ_B1) |=> (cmd_stb == '0) && !mode_wr); // R1
  AST_WIDE_READ_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (!io_addr[2] && io_size != SZ_B1) |-> (io_rdata[15:0] == 16'hFFFF)); // R1
  AST_ADDRPORT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    io_addr[2] |-> (io_rdata == '0)); // R2
  AST_ONE_CMD_STB: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cmd_stb)); // R3
  AST_MODE_WR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    mode_wr |-> $past(io_wr && io_size == SZ_B1 && io_addr[2:0] == 3'd1)); // R5

endmodule

// File: tb/sim_bmdma_regwin.sv
module sim_bmdma_regwin;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        io_wr = 1'b0;
  logic [3:0]  io_addr = '0;
  logic [1:0]  io_size = '0;
  logic [31:0] io_wdata = '0;
  logic [31:0] io_rdata;
  logic [7:0]  mode_in = '0;
  logic        mode_wr;
  logic [1:0]  mode_wr_mask;
  logic [1:0]  eng_busy = '0, eng_err_evt = '0, eng_irq_evt = '0;
  logic [1:0]  cmd_stb;
  logic [7:0]  cmd_byte;
  logic [15:0] tim_bytes;

  int checks = 0;
  int failures = 0;

  // Reference state
  logic [7:0] m_cmd [2];
  logic [7:0] m_tim [2];
  logic [1:0] m_flg [2];
  logic [1:0] m_rw  [2];

  always #2 clk = ~clk;

  bmdma_regwin u0 (
    .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_addr(io_addr),
    .io_size(io_size), .io_wdata(io_wdata), .io_rdata(io_rdata),
    .mode_in(mode_in), .mode_wr(mode_wr), .mode_wr_mask(mode_wr_mask),
    .eng_busy(eng_busy), .eng_err_evt(eng_err_evt), .eng_irq_evt(eng_irq_evt),
    .cmd_stb(cmd_stb), .cmd_byte(cmd_byte), .tim_bytes(tim_bytes)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_read(input logic [3:0] a, input logic [1:0] sz);
    int ch;
    logic [7:0] b;
    ch = int'(a[3]);
    if (a[2]) return 32'h0;                    // R2
    if (sz == 2'd1) return 32'h0000_FFFF;      // R1
    if (sz >= 2'd2) return 32'hFFFF_FFFF;      // R1
    unique case (a[1:0])
      2'd0: b = m_cmd[ch];
      2'd1: b = mode_in;
      2'd2: b = {1'b0, m_rw[ch], 2'b00, m_flg[ch][1], m_flg[ch][0], eng_busy[ch]};
      default: b = m_tim[ch];
    endcase
    return {24'h0, b};
  endfunction

  task automatic rd_check(input string req, input logic [3:0] a, input logic [1:0] sz);
    io_addr = a;
    io_size = sz;
    #1;
    check(req, io_rdata, exp_read(a, sz));
  endtask

  // One access plus events; model updated, strobes checked after the edge
  task automatic step(input logic wr, input logic [3:0] a, input logic [1:0] sz,
                      input logic [7:0] d, input logic [1:0] err, input logic [1:0] irq);
    logic [1:0] e_stb;
    logic       e_mwr;
    logic       ok;
    int         ch;
    @(negedge clk);
    io_wr = wr; io_addr = a; io_size = sz; io_wdata = {$urandom(), d};
    io_wdata[7:0] = d;
    eng_err_evt = err; eng_irq_evt = irq;
    ok = wr && !a[2] && (sz == 2'd0);
    ch = int'(a[3]);
    e_stb = '0;
    e_mwr = 1'b0;
    if (ok && a[1:0] == 2'd0) begin e_stb[ch] = 1'b1; m_cmd[ch] = d; end
    if (ok && a[1:0] == 2'd1) e_mwr = 1'b1;
    if (ok && a[1:0] == 2'd3) m_tim[ch] = d;
    if (ok && a[1:0] == 2'd2) begin
      m_rw[ch] = d[6:5];
      m_flg[ch][0] = m_flg[ch][0] & ~d[1];
      m_flg[ch][1] = m_flg[ch][1] & ~d[2];
    end
    for (int c = 0; c < 2; c++) begin
      if (err[c]) m_flg[c][0] = 1'b1;
      if (irq[c]) m_flg[c][1] = 1'b1;
    end
    @(negedge clk);
    check("R3 cmd_stb", {30'h0, cmd_stb}, {30'h0, e_stb});
    if (e_stb != 0) check("R3 cmd_byte", {24'h0, cmd_byte}, {24'h0, d});
    check("R5 mode_wr", {31'h0, mode_wr}, {31'h0, e_mwr});
    if (e_mwr) check("R5 mode_wr_mask", {30'h0, mode_wr_mask}, {30'h0, d[5:4]});
    check("R9 tim_bytes", {16'h0, tim_bytes}, {16'h0, m_tim[1], m_tim[0]});
    io_wr = 1'b0; eng_err_evt = '0; eng_irq_evt = '0;
  endtask

  initial begin
    repeat (2000000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    for (int c = 0; c < 2; c++) begin
      m_cmd[c] = '0; m_tim[c] = '0; m_flg[c] = '0; m_rw[c] = '0;
    end
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R10: reset state
    check("R10 cmd_stb", {30'h0, cmd_stb}, 32'h0);
    check("R10 mode_wr", {31'h0, mode_wr}, 32'h0);
    check("R10 tim_bytes", {16'h0, tim_bytes}, 32'h0);
    for (int a = 0; a < 16; a++) rd_check("R10 reset read", 4'(a), 2'd0);

    // R3: command on channel 1, then quiet cycle
    step(1'b1, 4'h8, 2'd0, 8'hA5, 2'b00, 2'b00);
    rd_check("R3 cmd readback", 4'h8, 2'd0);
    rd_check("R3 other channel", 4'h0, 2'd0);
    step(1'b0, 4'h8, 2'd0, 8'h00, 2'b00, 2'b00);

    // R4 / R5: shared mode byte
    mode_in = 8'h3C;
    step(1'b1, 4'h1, 2'd0, 8'hFF, 2'b00, 2'b00);
    rd_check("R4 mode ch0", 4'h1, 2'd0);
    rd_check("R4 mode ch1", 4'h9, 2'd0);
    step(1'b1, 4'h9, 2'd0, 8'h10, 2'b00, 2'b00);

    // R1: wide accesses
    step(1'b1, 4'h3, 2'd1, 8'h77, 2'b00, 2'b00);
    step(1'b1, 4'hB, 2'd2, 8'h66, 2'b00, 2'b00);
    step(1'b1, 4'h0, 2'd3, 8'h55, 2'b00, 2'b00);
    rd_check("R1 wide read 2", 4'h2, 2'd1);
    rd_check("R1 wide read 4", 4'h3, 2'd2);
    rd_check("R1 wide read 4x", 4'h8, 2'd3);
    rd_check("R1 timing kept", 4'h3, 2'd0);

    // R2: address port slot
    step(1'b1, 4'h4, 2'd0, 8'h99, 2'b00, 2'b00);
    step(1'b1, 4'hF, 2'd0, 8'h99, 2'b00, 2'b00);
    rd_check("R2 port read", 4'h4, 2'd0);
    rd_check("R2 port wide", 4'hC, 2'd2);

    // R6 / R7 / R8: status
    eng_busy = 2'b01;
    step(1'b0, 4'h0, 2'd0, 8'h00, 2'b01, 2'b10);
    rd_check("R7 err set ch0", 4'h2, 2'd0);
    rd_check("R7 irq set ch1", 4'hA, 2'd0);
    step(1'b1, 4'h2, 2'd0, 8'hFF, 2'b00, 2'b00);
    rd_check("R8 rw bits, R6 busy", 4'h2, 2'd0);
    step(1'b1, 4'hA, 2'd0, 8'h06, 2'b00, 2'b10);
    rd_check("R7 set beats clear", 4'hA, 2'd0);
    step(1'b1, 4'h2, 2'd0, 8'h00, 2'b00, 2'b00);
    rd_check("R6 busy kept", 4'h2, 2'd0);
    eng_busy = 2'b10;
    rd_check("R6 busy live", 4'hA, 2'd0);

    // R9: timing byte
    step(1'b1, 4'hB, 2'd0, 8'hC3, 2'b00, 2'b00);
    rd_check("R9 timing ch1", 4'hB, 2'd0);

    // Random mix
    for (int i = 0; i < 600; i++) begin
      logic [1:0] sz;
      sz = ($urandom_range(9) < 8) ? 2'd0 : 2'($urandom_range(3));
      eng_busy = 2'($urandom());
      mode_in  = 8'($urandom());
      step(($urandom_range(9) < 7), 4'($urandom()), sz, 8'($urandom()),
           ($urandom_range(6) == 0) ? 2'($urandom()) : 2'b00,
           ($urandom_range(6) == 0) ? 2'($urandom()) : 2'b00);
      rd_check("R7 status ch0", 4'h2, 2'd0);
      rd_check("R8 status ch1", 4'hA, 2'd0);
      rd_check("R1 random read", 4'($urandom()), ($urandom_range(3) == 0) ? 2'($urandom()) : 2'd0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule